// File: doc/BRIEF.md
# Supply-Fault Shutdown Sequencer

This block turns fault flags from a set of monitored supply rails into a controlled release of the power-supply-on line. Each rail reports an over-limit flag and an under-limit flag. A rail counts as a fault only when its shutdown enable is set. When an enabled fault is accepted, the block sets a sticky status bit. It then stops driving the power-supply-on line for a programmable window. When the window ends, it drives the line as the inverse of the sleep-state input, and it stays in that state until software clears the status bit.

Protection can be held off after core power comes up. When the mode strap is high, faults are ignored until power-good has been high for a programmable number of timer ticks. The count restarts on every power-good assertion. When the strap is low, faults are accepted at once. All time is measured in pulses of a millisecond tick-enable input.

A small register port holds three fields: the per-rail enables, the status bit, and a configuration byte that selects the window length and the arming delay. The status bit takes its reset from the standby-domain reset or from the main reset, depending on the strap.

Top module: `vprot_seq`

## Requirements
- R1: While armed, a set over-limit or under-limit flag on any rail whose enable bit is 1 sets the status bit to 1. The enable for rail i is bit i at address 0, and the status bit is bit 0 at address 1.
- R2: A flag on a rail whose enable bit is 0 neither sets the status bit nor disturbs the output-enable.
- R3: Writing address 1 with bit 0 at 1 clears the status bit. Writing it with bit 0 at 0 leaves the status bit unchanged. If a fault is being set in the same cycle, the set wins.
- R4: An accepted fault drops the output-enable for half_ticks × 2^W tick pulses, where W is configuration bits [3:2] (00, 01, 10, 11 give ×1, ×2, ×4, ×8). W resets to 01.
- R5: Whenever the output-enable is high, the output data equals the inverse of the sleep input one clock earlier.
- R6: With the strap at 1, a fault is accepted only once power-good has been high for A tick pulses. A is 0 for configuration bits [1:0]=00, and unit_ticks × 1, 2 or 4 for 01, 10 and 11. The field resets to 10. With the strap at 0, faults are accepted at once, whatever power-good is doing.
- R7: With the strap at 1, faults seen while power-good is low are ignored. A drop of power-good restarts the arming count.
- R8: A fault seen during the window or after it does not start a new window. The output stays in the post-window state until the status bit is cleared. After that, a new fault starts a fresh window.
- R9: After reset the enables read 0, the status bit reads 0 and the configuration reads 0x06. Unused bits and address 3 read 0.
- R10: The status bit is reset by the main reset when the strap is 0, and by the standby reset when the strap is 1. The other reset leaves it untouched.
- R11: A read returns data on reg_rdata one clock after the address is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Main synchronous reset, active high |
| sb_rst | input | 1 | Standby-domain synchronous reset, active high |
| tick_1k | input | 1 | Timer tick enable, one pulse per millisecond |
| mode_strap | input | 1 | Strap that enables arming delay and selects status reset |
| pwr_good | input | 1 | Core power-good |
| sleep_in | input | 1 | Sleep-state input |
| ov_flag | input | RAILS | Per-rail over-limit flags |
| uv_flag | input | RAILS | Per-rail under-limit flags |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Registered read data |
| psu_on_d | output | 1 | Power-supply-on data |
| psu_on_oe | output | 1 | Power-supply-on output enable |

## Verification
A wrong arming count shows up at the ports as a shift in the cycle where the output-enable falls after power-good rises. The shift is visible within the arming delay plus two clocks. A wrong window counter shows up as an output-enable low period of the wrong length, seen at the end of that period. A stuck or mis-reset status bit appears on the next read, or as a window that restarts or never returns to the held state. The bench sweeps every window and delay code with small tick scalings and compares these measured lengths against values it computes itself.

// File: rtl/vprot_pkg.sv
package vprot_pkg;

  typedef enum logic [1:0] {
    WS_IDLE = 2'd0,
    WS_OPEN = 2'd1,
    WS_HOLD = 2'd2
  } win_st_e;

  localparam logic [1:0] ADDR_EN  = 2'd0;
  localparam logic [1:0] ADDR_ST  = 2'd1;
  localparam logic [1:0] ADDR_CFG = 2'd2;

  localparam logic [1:0] WIN_RST = 2'b01;
  localparam logic [1:0] ARM_RST = 2'b10;

  function automatic int unsigned win_ticks(input logic [1:0] sel, input int unsigned half);
    return half << sel;
  endfunction

  function automatic int unsigned arm_ticks(input logic [1:0] sel, input int unsigned unit);
    if (sel == 2'b00) return 0;
    return unit << (sel - 2'd1);
  endfunction

endpackage

// File: rtl/vprot_regs.sv
module vprot_regs
  import vprot_pkg::*;
#(
  parameter int RAILS = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             stat_rst,
  input  logic             we,
  input  logic [1:0]       addr,
  input  logic [7:0]       wdata,
  input  logic             set_stat,
  output logic [RAILS-1:0] rail_en,
  output logic [1:0]       win_sel,
  output logic [1:0]       arm_sel,
  output logic             status,
  output logic [7:0]       rdata
);

  logic [7:0] rd_mux;

  always_ff @(posedge clk) begin
    if (rst) begin
      rail_en <= '0;
      win_sel <= WIN_RST;
      arm_sel <= ARM_RST;
    end else if (we) begin
      if (addr == ADDR_EN)  rail_en <= wdata[RAILS-1:0];
      if (addr == ADDR_CFG) {win_sel, arm_sel} <= wdata[3:0];
    end
  end

  always_ff @(posedge clk) begin
    if (stat_rst)                                status <= 1'b0;
    else if (set_stat)                           status <= 1'b1;
    else if (we && addr == ADDR_ST && wdata[0])  status <= 1'b0;
  end

  always_comb begin
    rd_mux = 8'h00;
    case (addr)
      ADDR_EN:  rd_mux[RAILS-1:0] = rail_en;
      ADDR_ST:  rd_mux[0] = status;
      ADDR_CFG: rd_mux[3:0] = {win_sel, arm_sel};
      default:  rd_mux = 8'h00;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= 8'h00;
    else     rdata <= rd_mux;
  end

  logic unused_ok;
  assign unused_ok = ^wdata[7:4];

endmodule

// File: rtl/vprot_arm.sv
module vprot_arm
  import vprot_pkg::*;
#(
  parameter int UNIT_TICKS = 50
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick,
  input  logic       strap,
  input  logic       pg,
  input  logic [1:0] arm_sel,
  output logic       armed
);

  localparam int MAX_T = UNIT_TICKS * 4;
  localparam int CW    = $clog2(MAX_T + 1);

  logic [CW-1:0] cnt;
  logic [CW-1:0] target;

  always_ff @(posedge clk) begin
    if (rst || !pg)                          cnt <= '0;
    else if (tick && cnt < CW'(MAX_T))       cnt <= cnt + 1'b1;
  end

  assign target = CW'(arm_ticks(arm_sel, UNIT_TICKS));
  assign armed  = !strap || (pg && cnt >= target);

endmodule

// File: rtl/vprot_win.sv
module vprot_win
  import vprot_pkg::*;
#(
  parameter int HALF_TICKS = 500
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick,
  input  logic       trip,
  input  logic       status,
  input  logic [1:0] win_sel,
  input  logic       sleep_in,
  output logic       psu_d,
  output logic       psu_oe
);

  localparam int MAX_W = HALF_TICKS * 8;
  localparam int WW    = $clog2(MAX_W + 1);

  win_st_e       st;
  logic [WW-1:0] wcnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      st   <= WS_IDLE;
      wcnt <= '0;
    end else begin
      case (st)
        WS_IDLE: if (trip) begin
          st   <= WS_OPEN;
          wcnt <= WW'(win_ticks(win_sel, HALF_TICKS));
        end
        WS_OPEN: if (tick) begin
          if (wcnt <= WW'(1)) st <= WS_HOLD;
          wcnt <= wcnt - 1'b1;
        end
        WS_HOLD: if (!status) st <= WS_IDLE;
        default: st <= WS_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      psu_d  <= 1'b0;
      psu_oe <= 1'b1;
    end else begin
      psu_oe <= (st != WS_OPEN);
      psu_d  <= (st != WS_OPEN) && !sleep_in;
    end
  end

endmodule

// File: rtl/vprot_seq.sv
module vprot_seq
  import vprot_pkg::*;
#(
  parameter int RAILS      = 3,
  parameter int HALF_TICKS = 500,
  parameter int UNIT_TICKS = 50
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sb_rst,
  input  logic             tick_1k,
  input  logic             mode_strap,
  input  logic             pwr_good,
  input  logic             sleep_in,
  input  logic [RAILS-1:0] ov_flag,
  input  logic [RAILS-1:0] uv_flag,
  input  logic             reg_we,
  input  logic [1:0]       reg_addr,
  input  logic [7:0]       reg_wdata,
  output logic [7:0]       reg_rdata,
  output logic             psu_on_d,
  output logic             psu_on_oe
);

  logic [RAILS-1:0] rail_en;
  logic [RAILS-1:0] rail_hit;
  logic [1:0]       win_sel;
  logic [1:0]       arm_sel;
  logic             status_q;
  logic             armed;
  logic             trip;
  logic             stat_rst;

  for (genvar i = 0; i < RAILS; i++) begin : g_rail
    assign rail_hit[i] = rail_en[i] && (ov_flag[i] || uv_flag[i]);
  end

  assign trip     = armed && (|rail_hit);
  assign stat_rst = mode_strap ? sb_rst : rst;

  vprot_regs #(.RAILS(RAILS)) u_regs (
    .clk(clk), .rst(rst), .stat_rst(stat_rst), .we(reg_we), .addr(reg_addr),
    .wdata(reg_wdata), .set_stat(trip), .rail_en(rail_en), .win_sel(win_sel),
    .arm_sel(arm_sel), .status(status_q), .rdata(reg_rdata)
  );

  vprot_arm #(.UNIT_TICKS(UNIT_TICKS)) u_arm (
    .clk(clk), .rst(rst), .tick(tick_1k), .strap(mode_strap), .pg(pwr_good),
    .arm_sel(arm_sel), .armed(armed)
  );

  vprot_win #(.HALF_TICKS(HALF_TICKS)) u_win (
    .clk(clk), .rst(rst), .tick(tick_1k), .trip(trip), .status(status_q),
    .win_sel(win_sel), .sleep_in(sleep_in), .psu_d(psu_on_d), .psu_oe(psu_on_oe)
  );

endmodule

// File: rtl/vprot_seq_chk.sv
module vprot_seq_chk #(
  parameter int HALF_TICKS = 500
) (
  input logic       clk,
  input logic       rst,
  input logic       sb_rst,
  input logic       stat_rst,
  input logic       mode_strap,
  input logic       pwr_good,
  input logic       sleep_in,
  input logic       reg_we,
  input logic [1:0] reg_addr,
  input logic [7:0] reg_wdata,
  input logic [7:0] reg_rdata,
  input logic       psu_on_d,
  input logic       psu_on_oe,
  input logic       status_q,
  input logic       trip
);

  localparam int LIM = HALF_TICKS * 8;
  localparam int LW  = $clog2(LIM + 2);

  logic [LW-1:0] low_run;

  always_ff @(posedge clk) begin
    if (rst || psu_on_oe)         low_run <= '0;
    else if (low_run < LW'(LIM + 1)) low_run <= low_run + 1'b1;
  end

  // R1: a window only opens after the status bit was set
  assert_fall_needs_status_R1: assert property (@(posedge clk) disable iff (rst)
    ($fell(psu_on_oe) && !$past(sb_rst) && !$past(rst)) |-> $past(status_q));

  // R3: write-one clears the status when no fault sets it
  assert_w1c_R3: assert property (@(posedge clk) disable iff (rst)
    (reg_we && reg_addr == 2'd1 && reg_wdata[0] && !trip && !stat_rst) |=> !status_q);

  // R4: window never exceeds the longest encoding
  assert_win_bound_R4: assert property (@(posedge clk) disable iff (rst)
    low_run <= LW'(LIM));

  // R5: driven data is the inverse of the previous sleep input
  assert_drive_inv_R5: assert property (@(posedge clk) disable iff (rst)
    (psu_on_oe && !$past(rst)) |-> (psu_on_d == !$past(sleep_in)));

  // R7: no fault is accepted while disarmed by low power-good
  assert_disarmed_R7: assert property (@(posedge clk) disable iff (rst)
    (mode_strap && !pwr_good && !status_q) |=> !status_q);

  // R9: status register upper bits read as zero
  assert_rsvd_zero_R9: assert property (@(posedge clk) disable iff (rst)
    ($past(reg_addr) == 2'd1 && !$past(rst)) |-> (reg_rdata[7:1] == 7'd0));

endmodule

bind vprot_seq vprot_seq_chk #(.HALF_TICKS(HALF_TICKS)) u_chk (
  .clk(clk), .rst(rst), .sb_rst(sb_rst), .stat_rst(stat_rst), .mode_strap(mode_strap),
  .pwr_good(pwr_good), .sleep_in(sleep_in), .reg_we(reg_we), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .psu_on_d(psu_on_d),
  .psu_on_oe(psu_on_oe), .status_q(status_q), .trip(trip)
);

// File: tb/vprot_seq_bench.sv
module vprot_seq_bench;

  localparam int RAILS = 3;
  localparam int HALF  = 3;
  localparam int UNIT  = 3;

  logic clk = 0;
  logic rst = 1, sb_rst = 1, tick_1k = 1, mode_strap = 0, pwr_good = 0, sleep_in = 0;
  logic [RAILS-1:0] ov_flag = '0, uv_flag = '0;
  logic reg_we = 0;
  logic [1:0] reg_addr = 0;
  logic [7:0] reg_wdata = 0;
  logic [7:0] reg_rdata;
  logic psu_on_d, psu_on_oe;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  vprot_seq #(.RAILS(RAILS), .HALF_TICKS(HALF), .UNIT_TICKS(UNIT)) u_vprot_seq (
    .clk(clk), .rst(rst), .sb_rst(sb_rst), .tick_1k(tick_1k), .mode_strap(mode_strap),
    .pwr_good(pwr_good), .sleep_in(sleep_in), .ov_flag(ov_flag), .uv_flag(uv_flag),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .psu_on_d(psu_on_d), .psu_on_oe(psu_on_oe)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 0;
  endtask

  task automatic rd(input logic [1:0] a, output int v);
    reg_addr = a;
    @(negedge clk);
    v = reg_rdata;
  endtask

  task automatic cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // measure negedges until oe drops (cap 200)
  task automatic wait_low(output int n);
    n = 0;
    do begin @(negedge clk); n++; end while (psu_on_oe && n < 200);
  endtask

  // count remaining low samples including the current one
  task automatic win_len(output int n);
    n = 1;
    @(negedge clk);
    while (!psu_on_oe && n < 200) begin n++; @(negedge clk); end
  endtask

  initial begin
    int v, n, t_arm, t_win, rail, stayed;
    cycles(3);
    rst = 0; sb_rst = 0;
    @(negedge clk);

    // R9 / R11 reset values and read latency
    chk(psu_on_oe == 1, "R9 oe after reset", psu_on_oe, 1);
    rd(2'd0, v); chk(v == 0, "R9 enables reset", v, 0);
    rd(2'd1, v); chk(v == 0, "R9 status reset", v, 0);
    rd(2'd2, v); chk(v == 8'h06, "R11 cfg reset read", v, 6);
    rd(2'd3, v); chk(v == 0, "R9 addr3 reads zero", v, 0);
    wr(2'd2, 8'hF6); rd(2'd2, v); chk(v == 8'h06, "R9 cfg upper bits zero", v, 6);

    // R2: disabled rails ignored (strap 0 means armed)
    wr(2'd0, 8'h01);
    ov_flag = 3'b110; uv_flag = 3'b110;
    cycles(5);
    chk(psu_on_oe == 1, "R2 oe undisturbed", psu_on_oe, 1);
    rd(2'd1, v); chk(v == 0, "R2 status stays clear", v, 0);
    ov_flag = 0; uv_flag = 0;

    // Sweep all window x arm codes with strap 1
    mode_strap = 1;
    for (int tt = 0; tt < 4; tt++) begin
      for (int ad = 0; ad < 4; ad++) begin
        rail  = (tt + ad) % RAILS;
        t_arm = (ad == 0) ? 0 : (UNIT << (ad - 1));
        t_win = HALF << tt;
        pwr_good = 0;
        wr(2'd2, 8'((tt << 2) | ad));
        wr(2'd0, 8'(1 << rail));
        if (ad[0]) uv_flag[rail] = 1; else ov_flag[rail] = 1;
        cycles(3);
        chk(psu_on_oe == 1, "R7 pg low ignores fault", psu_on_oe, 1);
        rd(2'd1, v); chk(v == 0, "R7 status clear while pg low", v, 0);
        if (ad == 2) begin
          pwr_good = 1; cycles(2); pwr_good = 0; @(negedge clk);
          chk(psu_on_oe == 1, "R7 short pg pulse ignored", psu_on_oe, 1);
        end
        pwr_good = 1;
        wait_low(n);
        chk(n == t_arm + 2, "R6 arming delay", n, t_arm + 2);
        win_len(n);
        chk(n == t_win, "R4 window length", n, t_win);
        chk(psu_on_d == !sleep_in, "R5 data after window", psu_on_d, !sleep_in);
        sleep_in = 1; @(negedge clk);
        chk(psu_on_d == 0, "R5 follows sleep high", psu_on_d, 0);
        sleep_in = 0; @(negedge clk);
        chk(psu_on_d == 1, "R5 follows sleep low", psu_on_d, 1);
        stayed = 1;
        for (int i = 0; i < 2 * t_win; i++) begin
          @(negedge clk);
          if (!psu_on_oe) stayed = 0;
        end
        chk(stayed == 1, "R8 no restart while held", stayed, 1);
        rd(2'd1, v); chk(v == 1, "R1 status set", v, 1);
        wr(2'd1, 8'hFE); rd(2'd1, v); chk(v == 1, "R3 write zero keeps status", v, 1);
        ov_flag = 0; uv_flag = 0;
        wr(2'd1, 8'h01); rd(2'd1, v); chk(v == 0, "R3 write one clears", v, 0);
        pwr_good = 0;
      end
    end

    // Strap 0: immediate acceptance and fresh window after clear
    mode_strap = 0; pwr_good = 0;
    wr(2'd2, 8'h0B); wr(2'd0, 8'h04);
    uv_flag[2] = 1;
    wait_low(n); chk(n == 2, "R6 strap0 immediate", n, 2);
    win_len(n); chk(n == HALF * 4, "R8 fresh window after clear", n, HALF * 4);
    uv_flag = 0;
    // R10 with strap 0: standby reset leaves status, main reset clears
    sb_rst = 1; @(negedge clk); sb_rst = 0;
    rd(2'd1, v); chk(v == 1, "R10 strap0 sb_rst keeps status", v, 1);
    rst = 1; @(negedge clk); rst = 0;
    rd(2'd1, v); chk(v == 0, "R10 strap0 rst clears status", v, 0);

    // R10 with strap 1
    mode_strap = 1; pwr_good = 1;
    wr(2'd0, 8'h02);
    cycles(3 * UNIT);
    ov_flag[1] = 1; cycles(2); ov_flag = 0;
    cycles(HALF * 2 + 4);
    rst = 1; @(negedge clk); rst = 0;
    rd(2'd1, v); chk(v == 1, "R10 strap1 rst keeps status", v, 1);
    sb_rst = 1; @(negedge clk); sb_rst = 0;
    rd(2'd1, v); chk(v == 0, "R10 strap1 sb_rst clears", v, 0);

    done = 1;
  end

  initial begin
    int k = 0;
    while (!done && k < 100000) begin @(negedge clk); k++; end
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", k, 0);
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule